// File: doc/BRIEF.md
# Address Window Decoder

This block resolves a 32-bit bus address to one of several programmable address windows. Each window has a base register and a size-mask register. One shared control word holds a per-window enable bit and a per-window two-bit access field. When a request is presented, every enabled window compares the upper half of the address with its base. Address bits that the window's mask marks as "inside the window" are excluded from the comparison. The lowest-numbered matching window wins. The decoder then reports, one cycle later, whether a window was hit, which one, its 8-bit target attribute code, and whether the access type was refused.

Software programs the windows through a small register port. The port selects the control word, a base register or a mask register by kind and window index. Two pulses, save and restore, copy the complete live register set into a shadow set and back. This lets boot code borrow the windows and later put the previous map back in one step. A two-state snapshot machine tracks whether the shadow holds valid content. Its states are SNAP_EMPTY and SNAP_HELD. There are three transitions: CAPTURE moves SNAP_EMPTY to SNAP_HELD on save; RECAPTURE keeps SNAP_HELD on a later save; APPLY keeps SNAP_HELD on restore. Restore is only honoured in SNAP_HELD.

Top module: `awin_decoder`

## Requirements
- R1: After reset, every register (control, all bases, all masks) reads 0, no window is enabled, and dec_valid, dec_hit, dec_err, dec_denied, dec_win, dec_attr are all 0.
- R2: Register access: reg_kind 0 selects the control word, 1 selects base[reg_idx], 2 selects mask[reg_idx]. The control word ignores reg_idx. A write stores the full 32-bit word. reg_rd returns the stored word on reg_rdata one cycle later (the value before any write in that same cycle). reg_rdata is 0 in a cycle after no read. Kind 3, or an index at or above NUM_WIN, reads 0, and a write to it changes nothing.
- R3: Window i matches when ((addr[31:16] XOR base_i[31:16]) AND NOT mask_i[31:16]) is zero. A mask of 0x0FFF0000 therefore spans 256 MiB and 0x03FF0000 spans 64 MiB.
- R4: Window i can only match while control bit i is 1.
- R5: When several enabled windows match, dec_win reports the lowest-numbered one.
- R6: When no enabled window matches, dec_hit is 0, dec_err is 1, dec_denied is 0, and dec_win and dec_attr are 0.
- R7: On a hit, dec_attr equals bits [15:8] of the winning window's base register.
- R8: Window i's access field is control bits [17+2i:16+2i]. Bit 1 of the field permits writes and bit 0 permits reads, so value 3 allows both. A hit whose access type is not permitted sets dec_denied and dec_err, with dec_hit still 1.
- R9: Each decode result appears on the clock edge after the one that samples req_valid, with dec_valid 1. It uses the register contents from before any write at that same edge. Without a request, all dec_* outputs are 0.
- R10: A snap_save pulse copies the whole live set into the shadow set. A later snap_restore copies the shadow set back into every live register.
- R11: snap_restore before any save has ever happened is ignored: the live registers keep their values, and a register write in that cycle still takes effect.
- R12: Same-cycle ordering: save captures the values from before a write in the same cycle, and the write still lands. An honoured restore overrides a write in the same cycle. Save together with restore acts as save alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_kind | input | 2 | Register kind: 0 control, 1 base, 2 mask, 3 none |
| reg_idx | input | IDX_W (3) | Window index for base and mask access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| snap_save | input | 1 | Copy live register set into the shadow set |
| snap_restore | input | 1 | Copy shadow set back into the live registers |
| req_valid | input | 1 | Decode request strobe |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| req_addr | input | 32 | Address to decode |
| dec_valid | output | 1 | Decode result valid |
| dec_hit | output | 1 | Some enabled window matched |
| dec_err | output | 1 | Miss or refused access |
| dec_denied | output | 1 | Matched window refuses this access type |
| dec_win | output | IDX_W (3) | Index of the winning window |
| dec_attr | output | 8 | Target attribute code of the winning window |

## Verification
The bench probes the exact edges of windows sized by their masks, such as the last address inside a 64 MiB window and the first one past it. A decoder that compared masked bits, or used the mask inverted, would hit or miss on the wrong side of such a boundary. Overlapping windows, together with later disabling the lower one, expose a wrong priority direction or an ignored enable bit. Read-only and write-only windows catch swapped permission bits. A restore before any save, and saves and restores that collide with a write in the same cycle, catch a snapshot machine that applies empty shadow contents or orders the updates wrongly.

// File: rtl/awd_pkg.sv
package awd_pkg;

    // Kind selector of the register port.
    typedef enum logic [1:0] {
        RK_CTRL = 2'd0,
        RK_BASE = 2'd1,
        RK_MASK = 2'd2,
        RK_NONE = 2'd3
    } reg_kind_e;

    // Shadow snapshot holder.
    typedef enum logic {
        SNAP_EMPTY = 1'b0,
        SNAP_HELD  = 1'b1
    } snap_state_e;

    localparam int REG_W      = 32;
    localparam int REGION_LSB = 16;
    localparam int PERM_LSB   = 16;
    localparam int ATTR_LSB   = 8;
    localparam int ATTR_W     = 8;

endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int IDX_W   = 3,
    parameter int HI_W    = REG_W - REGION_LSB
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr,
    input  logic                              reg_rd,
    input  logic [1:0]                        reg_kind,
    input  logic [IDX_W-1:0]                  reg_idx,
    input  logic [REG_W-1:0]                  reg_wdata,
    output logic [REG_W-1:0]                  reg_rdata,
    input  logic                              snap_save,
    input  logic                              snap_restore,
    output logic [NUM_WIN-1:0]                win_en,
    output logic [2*NUM_WIN-1:0]              win_perm,
    output logic [NUM_WIN-1:0][HI_W-1:0]      win_base_hi,
    output logic [NUM_WIN-1:0][HI_W-1:0]      win_mask_hi,
    output logic [NUM_WIN-1:0][ATTR_W-1:0]    win_attr
);

    logic [REG_W-1:0]                ctrl_q, sh_ctrl;
    logic [NUM_WIN-1:0][REG_W-1:0]   base_q, mask_q, sh_base, sh_mask;
    snap_state_e                     snap_q, snap_d;
    reg_kind_e                       kind;
    logic                            restore_go;
    logic [REG_W-1:0]                rd_mux;

    assign kind = reg_kind_e'(reg_kind);

    // Snapshot state register.
    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= SNAP_EMPTY;
        else        snap_q <= snap_d;
    end

    // Snapshot next state: CAPTURE, RECAPTURE, APPLY.
    always_comb begin
        snap_d = snap_q;
        unique case (snap_q)
            SNAP_EMPTY: if (snap_save) snap_d = SNAP_HELD;
            SNAP_HELD:  snap_d = SNAP_HELD;
        endcase
    end

    assign restore_go = (snap_q == SNAP_HELD) && snap_restore && !snap_save;

    // Live register set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            base_q <= '0;
            mask_q <= '0;
        end else if (restore_go) begin
            ctrl_q <= sh_ctrl;
            base_q <= sh_base;
            mask_q <= sh_mask;
        end else if (reg_wr) begin
            if (kind == RK_CTRL) ctrl_q <= reg_wdata;
            for (int i = 0; i < NUM_WIN; i++) begin
                if (reg_idx == IDX_W'(i)) begin
                    if (kind == RK_BASE) base_q[i] <= reg_wdata;
                    if (kind == RK_MASK) mask_q[i] <= reg_wdata;
                end
            end
        end
    end

    // Shadow register set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_ctrl <= '0;
            sh_base <= '0;
            sh_mask <= '0;
        end else if (snap_save) begin
            sh_ctrl <= ctrl_q;
            sh_base <= base_q;
            sh_mask <= mask_q;
        end
    end

    // Read mux.
    always_comb begin
        rd_mux = '0;
        unique case (kind)
            RK_CTRL: rd_mux = ctrl_q;
            RK_BASE: for (int i = 0; i < NUM_WIN; i++)
                         if (reg_idx == IDX_W'(i)) rd_mux = base_q[i];
            RK_MASK: for (int i = 0; i < NUM_WIN; i++)
                         if (reg_idx == IDX_W'(i)) rd_mux = mask_q[i];
            RK_NONE: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
        else             reg_rdata <= '0;
    end

    // Field extraction for the decoder.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_fields
        assign win_en[g]           = ctrl_q[g];
        assign win_perm[2*g +: 2]  = ctrl_q[PERM_LSB + 2*g +: 2];
        assign win_base_hi[g]      = base_q[g][REG_W-1:REGION_LSB];
        assign win_mask_hi[g]      = mask_q[g][REG_W-1:REGION_LSB];
        assign win_attr[g]         = base_q[g][ATTR_LSB +: ATTR_W];
    end

    // R11: restore with an empty shadow leaves the live set untouched.
    a_r11_restore_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_q == SNAP_EMPTY && snap_restore && !reg_wr) |=> ($stable(ctrl_q) && $stable(base_q) && $stable(mask_q)));

    // R12: an honoured restore wins over a concurrent write.
    a_r12_restore_overrides: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_q == SNAP_HELD && snap_restore && !snap_save) |=> (ctrl_q == $past(sh_ctrl) && base_q == $past(sh_base)));

    // R10: a save captures the live values of that cycle.
    a_r10_save_captures: assert property (@(posedge clk) disable iff (!rst_n)
        snap_save |=> (sh_ctrl == $past(ctrl_q) && sh_mask == $past(mask_q)));

endmodule

// File: rtl/awd_match.sv
module awd_match
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int HI_W    = REG_W - REGION_LSB
) (
    input  logic [HI_W-1:0]                  addr_hi,
    input  logic [NUM_WIN-1:0]               win_en,
    input  logic [NUM_WIN-1:0][HI_W-1:0]     win_base_hi,
    input  logic [NUM_WIN-1:0][HI_W-1:0]     win_mask_hi,
    output logic [NUM_WIN-1:0]               hit_vec
);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        logic [HI_W-1:0] diff;
        assign diff       = (addr_hi ^ win_base_hi[g]) & ~win_mask_hi[g];
        assign hit_vec[g] = win_en[g] && (diff == '0);
    end

endmodule

// File: rtl/awd_select.sv
module awd_select
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int IDX_W   = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic                              req_write,
    input  logic [NUM_WIN-1:0]                hit_vec,
    input  logic [2*NUM_WIN-1:0]              win_perm,
    input  logic [NUM_WIN-1:0][ATTR_W-1:0]    win_attr,
    output logic                              dec_valid,
    output logic                              dec_hit,
    output logic                              dec_err,
    output logic                              dec_denied,
    output logic [IDX_W-1:0]                  dec_win,
    output logic [ATTR_W-1:0]                 dec_attr
);

    logic              any_hit;
    logic [IDX_W-1:0]  sel_idx;
    logic [1:0]        sel_perm;
    logic [ATTR_W-1:0] sel_attr;
    logic              allowed;

    // Priority pick: scanning downward leaves the lowest index last.
    always_comb begin
        any_hit  = 1'b0;
        sel_idx  = '0;
        sel_perm = '0;
        sel_attr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit  = 1'b1;
                sel_idx  = IDX_W'(i);
                sel_perm = win_perm[2*i +: 2];
                sel_attr = win_attr[i];
            end
        end
    end

    assign allowed = req_write ? sel_perm[1] : sel_perm[0];

    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            dec_valid  <= 1'b0;
            dec_hit    <= 1'b0;
            dec_err    <= 1'b0;
            dec_denied <= 1'b0;
            dec_win    <= '0;
            dec_attr   <= '0;
        end else begin
            dec_valid  <= 1'b1;
            dec_hit    <= any_hit;
            dec_denied <= any_hit && !allowed;
            dec_err    <= !any_hit || !allowed;
            dec_win    <= sel_idx;
            dec_attr   <= sel_attr;
        end
    end

    // R9: a request yields a result on the next edge, and only then.
    a_r9_result_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid);
    a_r9_quiet_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!dec_valid && !dec_err && !dec_hit));

    // R6: a miss carries the error flag and no attribute.
    a_r6_miss_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_hit) |-> (dec_err && !dec_denied && dec_attr == '0 && dec_win == '0));

    // R8: refusal only happens on a hit.
    a_r8_denied_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        dec_denied |-> (dec_hit && dec_err));

    // R5: window 0 matching always wins.
    a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit_vec[0]) |=> (dec_hit && dec_win == '0));

endmodule

// File: rtl/awin_decoder.sv
module awin_decoder
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 5,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int HI_W   = REG_W - REGION_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_kind,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              snap_save,
    input  logic              snap_restore,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [31:0]       req_addr,
    output logic              dec_valid,
    output logic              dec_hit,
    output logic              dec_err,
    output logic              dec_denied,
    output logic [IDX_W-1:0]  dec_win,
    output logic [7:0]        dec_attr
);

    logic [NUM_WIN-1:0]               win_en;
    logic [2*NUM_WIN-1:0]             win_perm;
    logic [NUM_WIN-1:0][HI_W-1:0]     win_base_hi;
    logic [NUM_WIN-1:0][HI_W-1:0]     win_mask_hi;
    logic [NUM_WIN-1:0][ATTR_W-1:0]   win_attr;
    logic [NUM_WIN-1:0]               hit_vec;
    logic                             unused_addr_lo;

    assign unused_addr_lo = ^req_addr[REGION_LSB-1:0];

    awd_regfile #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .HI_W(HI_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_kind     (reg_kind),
        .reg_idx      (reg_idx),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .snap_save    (snap_save),
        .snap_restore (snap_restore),
        .win_en       (win_en),
        .win_perm     (win_perm),
        .win_base_hi  (win_base_hi),
        .win_mask_hi  (win_mask_hi),
        .win_attr     (win_attr)
    );

    awd_match #(.NUM_WIN(NUM_WIN), .HI_W(HI_W)) u_match (
        .addr_hi     (req_addr[REG_W-1:REGION_LSB]),
        .win_en      (win_en),
        .win_base_hi (win_base_hi),
        .win_mask_hi (win_mask_hi),
        .hit_vec     (hit_vec)
    );

    awd_select #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .hit_vec    (hit_vec),
        .win_perm   (win_perm),
        .win_attr   (win_attr),
        .dec_valid  (dec_valid),
        .dec_hit    (dec_hit),
        .dec_err    (dec_err),
        .dec_denied (dec_denied),
        .dec_win    (dec_win),
        .dec_attr   (dec_attr)
    );

endmodule

// File: tb/tb_awin_decoder.sv
module tb_awin_decoder;

    localparam int N  = 5;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 0, reg_rd = 0;
    logic [1:0]    reg_kind = 0;
    logic [IW-1:0] reg_idx = 0;
    logic [31:0]   reg_wdata = 0;
    logic [31:0]   reg_rdata;
    logic          snap_save = 0, snap_restore = 0;
    logic          req_valid = 0, req_write = 0;
    logic [31:0]   req_addr = 0;
    logic          dec_valid, dec_hit, dec_err, dec_denied;
    logic [IW-1:0] dec_win;
    logic [7:0]    dec_attr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state.
    logic [31:0] m_ctrl, s_ctrl;
    logic [31:0] m_base [N];
    logic [31:0] m_mask [N];
    logic [31:0] s_base [N];
    logic [31:0] s_mask [N];
    bit          s_held;

    always #10 clk = ~clk;

    awin_decoder #(.NUM_WIN(N)) dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_kind(reg_kind), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .snap_save(snap_save), .snap_restore(snap_restore),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .dec_valid(dec_valid), .dec_hit(dec_hit), .dec_err(dec_err),
        .dec_denied(dec_denied), .dec_win(dec_win), .dec_attr(dec_attr)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    function automatic logic [31:0] model_read(logic [1:0] k, int idx);
        if (k == 2'd0) return m_ctrl;
        if (idx >= N) return 32'h0;
        if (k == 2'd1) return m_base[idx];
        if (k == 2'd2) return m_mask[idx];
        return 32'h0;
    endfunction

    // One clock: predict, update model, advance, compare.
    task automatic cyc(string tag);
        logic        e_valid, e_hit, e_err, e_den;
        logic [31:0] e_win, e_attr, e_rdata;
        int          w;
        logic [1:0]  pf;
        e_valid = 0; e_hit = 0; e_err = 0; e_den = 0; e_win = 0; e_attr = 0;
        if (req_valid) begin
            e_valid = 1;
            w = -1;
            for (int i = 0; i < N; i++) begin
                if (w < 0 && m_ctrl[i] &&
                    (((req_addr[31:16] ^ m_base[i][31:16]) & ~m_mask[i][31:16]) == 16'h0))
                    w = i;
            end
            if (w < 0) e_err = 1;
            else begin
                e_hit  = 1;
                e_win  = w;
                e_attr = {24'h0, m_base[w][15:8]};
                pf     = m_ctrl[16 + 2*w +: 2];
                e_den  = req_write ? !pf[1] : !pf[0];
                e_err  = e_den;
            end
        end
        e_rdata = reg_rd ? model_read(reg_kind, int'(reg_idx)) : 32'h0;
        // Model update: restore beats write, save sees old values.
        if (snap_save) begin
            s_ctrl = m_ctrl;
            for (int i = 0; i < N; i++) begin s_base[i] = m_base[i]; s_mask[i] = m_mask[i]; end
        end
        if (s_held && snap_restore && !snap_save) begin
            m_ctrl = s_ctrl;
            for (int i = 0; i < N; i++) begin m_base[i] = s_base[i]; m_mask[i] = s_mask[i]; end
        end else if (reg_wr) begin
            if (reg_kind == 2'd0) m_ctrl = reg_wdata;
            else if (int'(reg_idx) < N) begin
                if (reg_kind == 2'd1) m_base[reg_idx] = reg_wdata;
                if (reg_kind == 2'd2) m_mask[reg_idx] = reg_wdata;
            end
        end
        if (snap_save) s_held = 1;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "dec_valid",  {31'h0, dec_valid},  {31'h0, e_valid});
        chk(tag, "dec_hit",    {31'h0, dec_hit},    {31'h0, e_hit});
        chk(tag, "dec_err",    {31'h0, dec_err},    {31'h0, e_err});
        chk(tag, "dec_denied", {31'h0, dec_denied}, {31'h0, e_den});
        chk(tag, "dec_win",    {29'h0, dec_win},    e_win);
        chk(tag, "dec_attr",   {24'h0, dec_attr},   e_attr);
        chk(tag, "reg_rdata",  reg_rdata,           e_rdata);
    endtask

    task automatic clear();
        reg_wr = 0; reg_rd = 0; snap_save = 0; snap_restore = 0; req_valid = 0; req_write = 0;
    endtask

    task automatic wreg(logic [1:0] k, int idx, logic [31:0] d, string tag);
        reg_wr = 1; reg_kind = k; reg_idx = IW'(idx); reg_wdata = d;
        cyc(tag); clear();
    endtask

    task automatic rreg(logic [1:0] k, int idx, string tag);
        reg_rd = 1; reg_kind = k; reg_idx = IW'(idx);
        cyc(tag); clear();
    endtask

    task automatic dec(logic [31:0] a, logic w, string tag);
        req_valid = 1; req_addr = a; req_write = w;
        cyc(tag); clear();
    endtask

    task automatic expect_dec(string tag, logic h, int win, logic [7:0] attr, logic den);
        chk(tag, "fixed hit",    {31'h0, dec_hit},    {31'h0, h});
        chk(tag, "fixed win",    {29'h0, dec_win},    win);
        chk(tag, "fixed attr",   {24'h0, dec_attr},   {24'h0, attr});
        chk(tag, "fixed denied", {31'h0, dec_denied}, {31'h0, den});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] ctrl_val;
        m_ctrl = 0; s_ctrl = 0; s_held = 0;
        for (int i = 0; i < N; i++) begin m_base[i] = 0; m_mask[i] = 0; s_base[i] = 0; s_mask[i] = 0; end

        // R1: reset state.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc("R1");
        for (int i = 0; i < N; i++) begin rreg(2'd1, i, "R1"); rreg(2'd2, i, "R1"); end
        rreg(2'd0, 0, "R1");
        chk("R1", "ctrl after reset", reg_rdata, 32'h0);
        dec(32'h0000_0000, 0, "R1");
        expect_dec("R1", 0, 0, 8'h00, 0);

        // R2: program windows and read back.
        wreg(2'd1, 0, 32'h0000_0E00, "R2"); wreg(2'd2, 0, 32'h0FFF_0000, "R2");
        wreg(2'd1, 1, 32'h1000_0D00, "R2"); wreg(2'd2, 1, 32'h0FFF_0000, "R2");
        wreg(2'd1, 2, 32'h2000_0B00, "R2"); wreg(2'd2, 2, 32'h0FFF_0000, "R2");
        wreg(2'd1, 3, 32'h3000_0700, "R2"); wreg(2'd2, 3, 32'h0FFF_0000, "R2");
        wreg(2'd1, 4, 32'h4000_1E00, "R2"); wreg(2'd2, 4, 32'h03FF_0000, "R2");
        ctrl_val = 32'h1F | (32'd3 << 16) | (32'd3 << 18) | (32'd1 << 20) | (32'd2 << 22) | (32'd3 << 24);
        wreg(2'd0, 6, ctrl_val, "R2");
        rreg(2'd1, 4, "R2");
        chk("R2", "base4 readback", reg_rdata, 32'h4000_1E00);
        wreg(2'd3, 0, 32'hDEAD_BEEF, "R2");
        wreg(2'd1, 6, 32'hDEAD_BEEF, "R2");
        rreg(2'd3, 0, "R2");
        chk("R2", "kind3 read", reg_rdata, 32'h0);
        rreg(2'd1, 6, "R2");
        chk("R2", "idx6 read", reg_rdata, 32'h0);
        rreg(2'd0, 0, "R2");
        chk("R2", "ctrl readback", reg_rdata, 32'h039F_001F);

        // R11: restore with nothing saved, with a concurrent write.
        snap_restore = 1; reg_wr = 1; reg_kind = 2'd2; reg_idx = 3'd3; reg_wdata = 32'h0FFF_0000;
        cyc("R11"); clear();
        rreg(2'd1, 0, "R11");
        chk("R11", "base0 kept", reg_rdata, 32'h0000_0E00);

        // R3, R7, R8, R6: decodes.
        dec(32'h0000_0100, 0, "R7"); expect_dec("R7", 1, 0, 8'h0E, 0);
        dec(32'h0FFF_FFFF, 1, "R3"); expect_dec("R3", 1, 0, 8'h0E, 0);
        dec(32'h1000_0000, 0, "R3"); expect_dec("R3", 1, 1, 8'h0D, 0);
        dec(32'h2000_0040, 1, "R8"); expect_dec("R8", 1, 2, 8'h0B, 1);
        chk("R8", "err on denied", {31'h0, dec_err}, 32'h1);
        dec(32'h2000_0040, 0, "R8"); expect_dec("R8", 1, 2, 8'h0B, 0);
        dec(32'h3100_0000, 0, "R8"); expect_dec("R8", 1, 3, 8'h07, 1);
        dec(32'h3100_0000, 1, "R8"); expect_dec("R8", 1, 3, 8'h07, 0);
        dec(32'h43FF_FFFF, 1, "R3"); expect_dec("R3", 1, 4, 8'h1E, 0);
        dec(32'h4400_0000, 0, "R6"); expect_dec("R6", 0, 0, 8'h00, 0);
        chk("R6", "err on miss", {31'h0, dec_err}, 32'h1);
        dec(32'h9000_0000, 1, "R6");

        // R9: back-to-back requests and a gap.
        req_valid = 1; req_addr = 32'h1234_0000; cyc("R9");
        req_addr = 32'h4000_0000; cyc("R9"); clear();
        cyc("R9");
        chk("R9", "valid low after gap", {31'h0, dec_valid}, 32'h0);

        // R10: save, scramble, restore.
        snap_save = 1; cyc("R10"); clear();

        // R5: overlap window 1 onto window 0.
        wreg(2'd1, 1, 32'h0000_5500, "R5");
        dec(32'h0000_1000, 0, "R5"); expect_dec("R5", 1, 0, 8'h0E, 0);
        // R4: disable window 0.
        wreg(2'd0, 0, ctrl_val & ~32'h1, "R4");
        dec(32'h0000_1000, 0, "R4"); expect_dec("R4", 1, 1, 8'h55, 0);

        snap_restore = 1; cyc("R10"); clear();
        rreg(2'd1, 1, "R10");
        chk("R10", "base1 restored", reg_rdata, 32'h1000_0D00);
        dec(32'h0000_1000, 0, "R10"); expect_dec("R10", 1, 0, 8'h0E, 0);

        // R12: save with write, then restore with write, then save+restore.
        snap_save = 1; reg_wr = 1; reg_kind = 2'd1; reg_idx = 3'd2; reg_wdata = 32'h2000_AA00;
        cyc("R12"); clear();
        rreg(2'd1, 2, "R12");
        chk("R12", "write landed with save", reg_rdata, 32'h2000_AA00);
        snap_restore = 1; reg_wr = 1; reg_kind = 2'd1; reg_idx = 3'd3; reg_wdata = 32'h7700_0000;
        cyc("R12"); clear();
        rreg(2'd1, 2, "R12");
        chk("R12", "restore got pre-write value", reg_rdata, 32'h2000_0B00);
        rreg(2'd1, 3, "R12");
        chk("R12", "write dropped by restore", reg_rdata, 32'h3000_0700);
        wreg(2'd2, 4, 32'h0000_0000, "R12");
        snap_save = 1; snap_restore = 1; cyc("R12"); clear();
        rreg(2'd2, 4, "R12");
        chk("R12", "save+restore acts as save", reg_rdata, 32'h0);

        // Mixed random traffic against the model.
        for (int n = 0; n < 600; n++) begin
            reg_wr       = ($urandom_range(0, 3) == 0);
            reg_rd       = ($urandom_range(0, 2) == 0);
            reg_kind     = 2'($urandom_range(0, 3));
            reg_idx      = IW'($urandom_range(0, 7));
            reg_wdata    = {4'($urandom_range(0, 5)), 28'($urandom)};
            if (reg_kind == 2'd2) reg_wdata[31:28] = 4'h0;
            snap_save    = ($urandom_range(0, 30) == 0);
            snap_restore = ($urandom_range(0, 30) == 0);
            req_valid    = ($urandom_range(0, 1) == 1);
            req_write    = 1'($urandom_range(0, 1));
            req_addr     = {4'($urandom_range(0, 5)), 28'($urandom)};
            cyc("R3");
        end
        clear();
        cyc("R9");

        done = 1;
        summary();
        $finish;
    end

endmodule